// File: doc/BRIEF.md
# Trap-Return Status Update Unit

This unit performs the architectural side of the two trap-return instructions: the return from supervisor mode and the return from machine mode. For each request it receives a snapshot of the hart's state: the current privilege, the virtualization flag, a packed vector of the status bits that a return reads and writes, the two trap-control bits that can forbid a supervisor return, both saved exception PCs, and five static configuration flags. From these it decides whether the return is allowed.

When the return is allowed, the unit delivers the return PC, the rewritten status vector, the privilege and virtualization state to resume in, and a request to exchange the hypervisor register banks. When the return is refused, it delivers a trap with its cause. In that case it leaves every piece of state exactly as it was given.

One request is accepted per cycle. The full answer appears on a registered response one clock later. The surrounding pipeline stores the state and redirects fetch.

Top module: `trap_return_unit`

## Requirements
- R1: A supervisor return issued at user privilege (encoding 0) traps with cause 2 (illegal instruction). Privilege encodings: 0 user, 1 supervisor, 3 machine.
- R2: A machine return issued at any privilege other than 3 traps with cause 2.
- R3: The return traps with cause 0 (misaligned target) when compressed support is off and bits [1:0] of the selected saved PC are not both zero. The privilege check of R1/R2 takes precedence. With compressed support on, the low bits never cause a trap.
- R4: A supervisor return that passes R1 and R3 traps with cause 2 when the trap-SR control bit is set and the privilege is not 3. Otherwise it traps with cause 22 (virtual instruction) when the virtualization flag is set and the virtual trap-SR bit is set.
- R5: The status vector is laid out as: bit 0 SIE, 1 SPIE, 2 SPP, 3 MIE, 4 MPIE, [6:5] MPP, 7 MPV, 8 MPRV, 9 SPV. A successful supervisor return copies SPIE into SIE, sets SPIE, clears SPP, and resumes at privilege {0,old SPP}. It returns the saved supervisor PC.
- R6: A successful machine return copies MPIE into MIE, sets MPIE, and clears MPV. It writes MPP to 0 when user mode is supported and to 3 otherwise. It resumes at the old MPP and returns the saved machine PC.
- R7: When the spec-1.12 flag is set, a supervisor return clears MPRV. A machine return clears MPRV only when the old MPP is not 3. Otherwise MPRV is kept.
- R8: A machine return that passes R2 and R3 traps with cause 1 (instruction access fault) when memory protection is present with zero rules and the old MPP is not 3.
- R9: With hypervisor support, a supervisor return taken while not virtualized resumes with virtualization equal to the old SPV, clears SPV, and requests a swap exactly when SPV was 1. A machine return with hypervisor support resumes with virtualization equal to the old MPV and requests a swap exactly when MPV was 1. In every other case virtualization is unchanged and no swap is requested.
- R10: The response is valid exactly one cycle after a request and is low in the cycle after an idle cycle.
- R11: On a trap, the response carries the status vector, privilege and virtualization exactly as given, a zero PC, and no swap request.
- R12: After reset, the response valid, trap and swap outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A return instruction is presented this cycle |
| req_mret | input | 1 | 1 selects machine return, 0 supervisor return |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Currently virtualized |
| stat_i | input | 10 | Status vector (layout in R5) |
| tsr_i | input | 1 | Trap-SR control bit |
| vtsr_i | input | 1 | Virtual trap-SR control bit |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| mepc_i | input | XLEN | Saved machine exception PC |
| cfg_rvc | input | 1 | Compressed instructions supported |
| cfg_rvu | input | 1 | User mode supported |
| cfg_rvh | input | 1 | Hypervisor supported |
| cfg_v112 | input | 1 | Spec version 1.12 or later |
| cfg_pmp_empty | input | 1 | Memory protection present with zero rules |
| rsp_valid | output | 1 | Response valid |
| rsp_trap | output | 1 | Return refused, trap raised |
| rsp_cause | output | 5 | Trap cause |
| rsp_pc | output | XLEN | Return PC (zero on trap) |
| rsp_stat | output | 10 | Updated status vector |
| rsp_priv | output | 2 | Privilege to resume in |
| rsp_virt | output | 1 | Virtualization to resume in |
| rsp_swap | output | 1 | Swap hypervisor register banks |

## Verification
Every result of this unit goes through a single register stage: the trap decision, the cause, the PC, the status vector, the privilege, the virtualization state and the swap request are all due on the clock edge that follows the request. The bench applies each request half a cycle before a rising edge. It then samples all outputs at the next falling edge, one full edge after capture, and compares them together against its own model. An idle cycle is inserted periodically so that the valid output can be seen to drop in the following cycle.

// File: rtl/trp_pkg.sv
package trp_pkg;

    localparam int CAUSE_W = 5;
    localparam int STAT_W  = 10;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ACCESS   = 5'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

    // Packed so that bit 0 is sie and bit 9 is spv.
    typedef struct packed {
        logic       spv;
        logic       mprv;
        logic       mpv;
        logic [1:0] mpp;
        logic       mpie;
        logic       mie;
        logic       spp;
        logic       spie;
        logic       sie;
    } stat_t;

endpackage

// File: rtl/trp_check.sv
module trp_check
    import trp_pkg::*;
(
    input  logic               is_mret,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic [1:0]         epc_lo,
    input  logic               rvc,
    input  logic               tsr,
    input  logic               vtsr,
    input  logic               pmp_empty,
    input  logic [1:0]         old_mpp,
    output logic               trap,
    output logic [CAUSE_W-1:0] cause
);

    logic misal;
    assign misal = !rvc && (epc_lo != 2'b00);

    always_comb begin
        trap  = 1'b0;
        cause = CAUSE_MISALIGN;
        if (is_mret) begin
            if (priv != PRIV_M) begin
                trap  = 1'b1;
                cause = CAUSE_ILLEGAL;
            end else if (misal) begin
                trap  = 1'b1;
                cause = CAUSE_MISALIGN;
            end else if (pmp_empty && old_mpp != PRIV_M) begin
                trap  = 1'b1;
                cause = CAUSE_ACCESS;
            end
        end else begin
            if (priv == PRIV_U) begin
                trap  = 1'b1;
                cause = CAUSE_ILLEGAL;
            end else if (misal) begin
                trap  = 1'b1;
                cause = CAUSE_MISALIGN;
            end else if (tsr && priv != PRIV_M) begin
                trap  = 1'b1;
                cause = CAUSE_ILLEGAL;
            end else if (virt && vtsr) begin
                trap  = 1'b1;
                cause = CAUSE_VIRT;
            end
        end
    end

    // R3: with compressed support no trap can carry the misaligned cause
    always_comb begin
        if (rvc && trap) begin
            assert_no_misal_with_rvc_R3: assert (cause != CAUSE_MISALIGN);
        end
    end

endmodule

// File: rtl/trp_status.sv
module trp_status
    import trp_pkg::*;
(
    input  logic       is_mret,
    input  logic       virt,
    input  stat_t      stat,
    input  logic       rvu,
    input  logic       rvh,
    input  logic       v112,
    output stat_t      nstat,
    output logic [1:0] npriv,
    output logic       nvirt,
    output logic       swap
);

    always_comb begin
        nstat = stat;
        nvirt = virt;
        swap  = 1'b0;
        if (is_mret) begin
            npriv      = stat.mpp;
            nstat.mie  = stat.mpie;
            nstat.mpie = 1'b1;
            nstat.mpp  = rvu ? PRIV_U : PRIV_M;
            nstat.mpv  = 1'b0;
            if (v112 && stat.mpp != PRIV_M) begin
                nstat.mprv = 1'b0;
            end
            if (rvh) begin
                nvirt = stat.mpv;
                swap  = stat.mpv;
            end
        end else begin
            npriv      = {1'b0, stat.spp};
            nstat.sie  = stat.spie;
            nstat.spie = 1'b1;
            nstat.spp  = 1'b0;
            if (v112) begin
                nstat.mprv = 1'b0;
            end
            if (rvh && !virt) begin
                nstat.spv = 1'b0;
                nvirt     = stat.spv;
                swap      = stat.spv;
            end
        end
    end

    // R9: a swap is only requested together with entering virtualized mode
    always_comb begin
        if (swap) begin
            assert_swap_enters_virt_R9: assert (nvirt);
        end
    end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
    import trp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_mret,
    input  logic [1:0]              cur_priv,
    input  logic                    cur_virt,
    input  logic [9:0]              stat_i,
    input  logic                    tsr_i,
    input  logic                    vtsr_i,
    input  logic [XLEN-1:0]         sepc_i,
    input  logic [XLEN-1:0]         mepc_i,
    input  logic                    cfg_rvc,
    input  logic                    cfg_rvu,
    input  logic                    cfg_rvh,
    input  logic                    cfg_v112,
    input  logic                    cfg_pmp_empty,
    output logic                    rsp_valid,
    output logic                    rsp_trap,
    output logic [4:0]              rsp_cause,
    output logic [XLEN-1:0]         rsp_pc,
    output logic [9:0]              rsp_stat,
    output logic [1:0]              rsp_priv,
    output logic                    rsp_virt,
    output logic                    rsp_swap
);

    localparam int LO_W = 2;

    typedef struct packed {
        logic               valid;
        logic               trap;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0]    pc;
        stat_t              stat;
        logic [1:0]         priv;
        logic               virt;
        logic               swap;
    } rsp_t;

    stat_t              stat_in;
    stat_t              stat_upd;
    logic [XLEN-1:0]    epc_sel;
    logic               chk_trap;
    logic [CAUSE_W-1:0] chk_cause;
    logic [1:0]         upd_priv;
    logic               upd_virt;
    logic               upd_swap;
    rsp_t               rsp_d;
    rsp_t               rsp_q;

    assign stat_in = stat_t'(stat_i);
    assign epc_sel = req_mret ? mepc_i : sepc_i;

    trp_check u_check (
        .is_mret   (req_mret),
        .priv      (cur_priv),
        .virt      (cur_virt),
        .epc_lo    (epc_sel[LO_W-1:0]),
        .rvc       (cfg_rvc),
        .tsr       (tsr_i),
        .vtsr      (vtsr_i),
        .pmp_empty (cfg_pmp_empty),
        .old_mpp   (stat_in.mpp),
        .trap      (chk_trap),
        .cause     (chk_cause)
    );

    trp_status u_status (
        .is_mret (req_mret),
        .virt    (cur_virt),
        .stat    (stat_in),
        .rvu     (cfg_rvu),
        .rvh     (cfg_rvh),
        .v112    (cfg_v112),
        .nstat   (stat_upd),
        .npriv   (upd_priv),
        .nvirt   (upd_virt),
        .swap    (upd_swap)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.trap  = chk_trap;
            rsp_d.cause = chk_cause;
            if (chk_trap) begin
                rsp_d.pc   = '0;
                rsp_d.stat = stat_in;
                rsp_d.priv = cur_priv;
                rsp_d.virt = cur_virt;
                rsp_d.swap = 1'b0;
            end else begin
                rsp_d.pc   = epc_sel;
                rsp_d.stat = stat_upd;
                rsp_d.priv = upd_priv;
                rsp_d.virt = upd_virt;
                rsp_d.swap = upd_swap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_trap  = rsp_q.trap;
    assign rsp_cause = rsp_q.cause;
    assign rsp_pc    = rsp_q.pc;
    assign rsp_stat  = rsp_q.stat;
    assign rsp_priv  = rsp_q.priv;
    assign rsp_virt  = rsp_q.virt;
    assign rsp_swap  = rsp_q.swap;

    // R10: a response follows a request by exactly one cycle
    assert_rsp_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R1: supervisor return from user privilege is refused
    assert_sret_user_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mret && cur_priv == PRIV_U) |=> (rsp_trap && rsp_cause == CAUSE_ILLEGAL));

    // R2: machine return below machine privilege is refused
    assert_mret_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mret && cur_priv != PRIV_M) |=> (rsp_trap && rsp_cause == CAUSE_ILLEGAL));

    // R11: a refused return keeps privilege and requests no swap
    assert_trap_keeps_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap) |-> (!rsp_swap && rsp_priv == $past(cur_priv) && rsp_stat == $past(stat_i)));

    // R6: a completed machine return leaves MPIE set and MPV clear
    assert_mret_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_trap && $past(req_mret)) |-> (rsp_stat[4] && !rsp_stat[7]));

endmodule

// File: tb/trap_return_unit_tb.sv
module trap_return_unit_tb;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_mret = 1'b0;
    logic [1:0]      cur_priv = '0;
    logic            cur_virt = 1'b0;
    logic [9:0]      stat_i = '0;
    logic            tsr_i = 1'b0;
    logic            vtsr_i = 1'b0;
    logic [XLEN-1:0] sepc_i = '0;
    logic [XLEN-1:0] mepc_i = '0;
    logic            cfg_rvc = 1'b0;
    logic            cfg_rvu = 1'b0;
    logic            cfg_rvh = 1'b0;
    logic            cfg_v112 = 1'b0;
    logic            cfg_pmp_empty = 1'b0;
    logic            rsp_valid;
    logic            rsp_trap;
    logic [4:0]      rsp_cause;
    logic [XLEN-1:0] rsp_pc;
    logic [9:0]      rsp_stat;
    logic [1:0]      rsp_priv;
    logic            rsp_virt;
    logic            rsp_swap;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    trap_return_unit #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mret(req_mret),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .stat_i(stat_i),
        .tsr_i(tsr_i), .vtsr_i(vtsr_i), .sepc_i(sepc_i), .mepc_i(mepc_i),
        .cfg_rvc(cfg_rvc), .cfg_rvu(cfg_rvu), .cfg_rvh(cfg_rvh),
        .cfg_v112(cfg_v112), .cfg_pmp_empty(cfg_pmp_empty),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
        .rsp_pc(rsp_pc), .rsp_stat(rsp_stat), .rsp_priv(rsp_priv),
        .rsp_virt(rsp_virt), .rsp_swap(rsp_swap)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench model; returns the expected response and the requirement it mainly exercises
    task automatic model(output logic e_trap, output logic [4:0] e_cause,
                         output logic [XLEN-1:0] e_pc, output logic [9:0] e_stat,
                         output logic [1:0] e_priv, output logic e_virt,
                         output logic e_swap, output string tag);
        logic [XLEN-1:0] epc;
        logic            mis;
        logic [1:0]      mpp;
        epc    = req_mret ? mepc_i : sepc_i;
        mis    = !cfg_rvc && (epc[1:0] != 2'b00);
        mpp    = stat_i[6:5];
        e_trap = 1'b1;
        e_cause = 5'd0;
        if (req_mret) begin
            if (cur_priv != 2'd3) begin e_cause = 5'd2; tag = "R2"; end
            else if (mis) begin e_cause = 5'd0; tag = "R3"; end
            else if (cfg_pmp_empty && mpp != 2'd3) begin e_cause = 5'd1; tag = "R8"; end
            else e_trap = 1'b0;
        end else begin
            if (cur_priv == 2'd0) begin e_cause = 5'd2; tag = "R1"; end
            else if (mis) begin e_cause = 5'd0; tag = "R3"; end
            else if (tsr_i && cur_priv != 2'd3) begin e_cause = 5'd2; tag = "R4"; end
            else if (cur_virt && vtsr_i) begin e_cause = 5'd22; tag = "R4"; end
            else e_trap = 1'b0;
        end
        e_stat = stat_i;
        e_priv = cur_priv;
        e_virt = cur_virt;
        e_swap = 1'b0;
        e_pc   = '0;
        if (e_trap) begin
            e_cause = e_cause;
        end else if (req_mret) begin
            tag = "R6";
            e_pc = epc;
            e_priv = mpp;
            e_stat[3] = stat_i[4];
            e_stat[4] = 1'b1;
            e_stat[6:5] = cfg_rvu ? 2'd0 : 2'd3;
            e_stat[7] = 1'b0;
            if (cfg_v112 && mpp != 2'd3) begin e_stat[8] = 1'b0; tag = "R7"; end
            if (cfg_rvh) begin e_virt = stat_i[7]; e_swap = stat_i[7]; tag = "R9"; end
        end else begin
            tag = "R5";
            e_pc = epc;
            e_priv = {1'b0, stat_i[2]};
            e_stat[0] = stat_i[1];
            e_stat[1] = 1'b1;
            e_stat[2] = 1'b0;
            if (cfg_v112) begin e_stat[8] = 1'b0; tag = "R7"; end
            if (cfg_rvh && !cur_virt) begin
                e_stat[9] = 1'b0; e_virt = stat_i[9]; e_swap = stat_i[9]; tag = "R9";
            end
        end
    endtask

    // Inputs are already set (at a falling edge); capture at the rising edge, sample at the next falling edge
    task automatic run_and_check;
        logic            e_trap, e_virt, e_swap;
        logic [4:0]      e_cause;
        logic [XLEN-1:0] e_pc;
        logic [9:0]      e_stat;
        logic [1:0]      e_priv;
        string           tag;
        req_valid = 1'b1;
        model(e_trap, e_cause, e_pc, e_stat, e_priv, e_virt, e_swap, tag);
        @(negedge clk);
        check({"R10 valid ", tag}, 64'(rsp_valid), 64'(1'b1));
        check({"trap ", tag}, 64'(rsp_trap), 64'(e_trap));
        if (e_trap) begin
            check({"cause ", tag}, 64'(rsp_cause), 64'(e_cause));
            check({"R11 state ", tag}, {rsp_stat, rsp_priv, rsp_virt, rsp_swap, rsp_pc},
                                       {e_stat, e_priv, e_virt, e_swap, e_pc});
        end else begin
            check({"result ", tag}, {rsp_stat, rsp_priv, rsp_virt, rsp_swap, rsp_pc},
                                    {e_stat, e_priv, e_virt, e_swap, e_pc});
        end
    endtask

    task automatic set_req(input logic m, input logic [1:0] p, input logic v, input logic [9:0] s,
                           input logic t, input logic vt, input logic [XLEN-1:0] se,
                           input logic [XLEN-1:0] me, input logic [4:0] cfg);
        req_mret = m; cur_priv = p; cur_virt = v; stat_i = s; tsr_i = t; vtsr_i = vt;
        sepc_i = se; mepc_i = me;
        {cfg_rvc, cfg_rvu, cfg_rvh, cfg_v112, cfg_pmp_empty} = cfg;
    endtask

    initial begin
        #3_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 valid", 64'(rsp_valid), 64'(0));
        check("R12 trap", 64'(rsp_trap), 64'(0));
        check("R12 swap", 64'(rsp_swap), 64'(0));
        rst_n = 1'b1;

        // R1: sret from U
        set_req(1'b0, 2'd0, 1'b0, 10'h006, 1'b0, 1'b0, 32'h100, 32'h200, 5'b11000); run_and_check();
        // R2: mret from S
        set_req(1'b1, 2'd1, 1'b0, 10'h060, 1'b0, 1'b0, 32'h100, 32'h200, 5'b11000); run_and_check();
        // R3: misaligned sepc without compressed support
        set_req(1'b0, 2'd1, 1'b0, 10'h006, 1'b0, 1'b0, 32'h102, 32'h200, 5'b01000); run_and_check();
        // R3: same address with compressed support returns
        set_req(1'b0, 2'd1, 1'b0, 10'h006, 1'b0, 1'b0, 32'h102, 32'h200, 5'b11000); run_and_check();
        // R3 vs R1 priority: U privilege and misaligned gives cause 2
        set_req(1'b0, 2'd0, 1'b0, 10'h006, 1'b0, 1'b0, 32'h103, 32'h200, 5'b01000); run_and_check();
        // R4: tsr at S
        set_req(1'b0, 2'd1, 1'b0, 10'h006, 1'b1, 1'b0, 32'h100, 32'h200, 5'b11000); run_and_check();
        // R4: tsr ignored at M
        set_req(1'b0, 2'd3, 1'b0, 10'h006, 1'b1, 1'b0, 32'h100, 32'h200, 5'b11000); run_and_check();
        // R4: virtual trap with vtsr
        set_req(1'b0, 2'd1, 1'b1, 10'h006, 1'b0, 1'b1, 32'h100, 32'h200, 5'b11100); run_and_check();
        // R8: empty protection, return to S
        set_req(1'b1, 2'd3, 1'b0, 10'h030, 1'b0, 1'b0, 32'h100, 32'h200, 5'b11001); run_and_check();
        // R8: empty protection, return to M allowed; R7 keeps MPRV
        set_req(1'b1, 2'd3, 1'b0, 10'h170, 1'b0, 1'b0, 32'h100, 32'h200, 5'b10011); run_and_check();
        // R6/R7: mret to U with MPRV cleared
        set_req(1'b1, 2'd3, 1'b0, 10'h110, 1'b0, 1'b0, 32'h100, 32'h204, 5'b11010); run_and_check();
        // R9: sret with SPV set enters virtualization and swaps
        set_req(1'b0, 2'd1, 1'b0, 10'h206, 1'b0, 1'b0, 32'h140, 32'h200, 5'b11110); run_and_check();
        // R9: mret with MPV set
        set_req(1'b1, 2'd3, 1'b0, 10'h0A0, 1'b0, 1'b0, 32'h100, 32'h300, 5'b11100); run_and_check();
        // R10: idle cycle drops valid
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 idle", 64'(rsp_valid), 64'(0));

        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            set_req(r[0], (r[3:1] > 3'd2) ? 2'd3 : r[2:1], r[4], 10'($urandom),
                    (r[7:5] == 3'd0), (r[10:8] == 3'd0),
                    {$urandom, 2'b00} | 32'((r[13:11] == 3'd0) ? r[15:14] : 2'b00),
                    {$urandom, 2'b00} | 32'((r[18:16] == 3'd0) ? r[20:19] : 2'b00),
                    {r[21] | r[22], r[23], r[24], r[25], (r[28:26] == 3'd0)});
            run_and_check();
            if (r[31:29] == 3'd0) begin
                req_valid = 1'b0;
                @(negedge clk);
                check("R10 idle", 64'(rsp_valid), 64'(0));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule